// File: doc/BRIEF.md
# Data-Side Burst Transfer Control Generator

This block turns load/store commands from a core's load/store unit into the per-cycle control signals of a data memory port. It accepts four kinds of command: a single load or store of a byte, halfword or word; a multi-register load or store of a given number of words; and a coprocessor data transfer. For each command it drives the request strobe (active low), a sequential flag, a look-ahead flag, the direction, a two-bit size code and an address that steps by one word per beat. It also holds a stall line toward the instruction pipeline while a multi-register transfer runs.

The look-ahead flag reports one cycle early whether the next cycle will be a sequential access. External memory logic can then decode a burst continuation a full cycle before the sequential flag confirms it.

Commands enter on a valid/ready port. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high when the block is idle and during the final beat of the current command, so commands can follow each other with no gap. While `cmd_ready` is low, the requester must hold `cmd_valid` and the command fields steady. The first beat of an accepted command is driven in the cycle after the accepting edge.

Top module: `dburst_ctrl`

## Requirements
- R1: After reset and whenever no command is in progress, `mem_req_n` is 1, `mem_seq`, `mem_more` and `pipe_stall` are 0, and `cmd_ready` is 1.
- R2: A single transfer (`cmd_op` = 0) produces exactly one beat in the cycle after acceptance. In that beat `mem_req_n` is 0, `mem_seq`, `mem_more` and `pipe_stall` are 0, and the address equals `cmd_addr`.
- R3: Size codes are 00 for a byte, 01 for a halfword and 10 for a word. A single transfer passes `cmd_size` through. A requested code of 11 is driven as 10, so `mem_size` never shows 11.
- R4: A multi-register transfer (`cmd_op` = 1) of N ≥ 2 words produces N back-to-back beats with `mem_req_n` = 0 and size 10. Beat k (counting from 0) carries address `cmd_addr` + 4k.
- R5: `mem_seq` is 0 on the first beat of a multi-register transfer and 1 on every later beat.
- R6: `mem_more` is 1 on the first N−1 beats of an N-word multi-register transfer and 0 on its last beat. In every cycle it equals the value of `mem_seq` in the following cycle.
- R7: `mem_more` is 1 only while `mem_req_n` is 0, and only during a multi-register transfer.
- R8: `pipe_stall` is 1 on every beat of a multi-register transfer of N ≥ 2 words and 0 otherwise. It is 0 in the acceptance cycle, which leaves that cycle open for one instruction fetch.
- R9: A multi-register transfer with a count of 0 or 1 produces one word beat, with `mem_seq`, `mem_more` and `pipe_stall` all 0.
- R10: A coprocessor transfer (`cmd_op` = 2) produces one beat with `mem_req_n` = 1, `mem_size` = 10 whatever `cmd_size` holds, `mem_write` = `cmd_write`, and `mem_seq` and `mem_more` 0.
- R11: `cmd_ready` is 1 on the final beat of a command. A command accepted on that edge starts its first beat in the very next cycle.
- R12: `mem_write`, `mem_size` and `mem_addr` are valid in the same cycle as each beat's request, and `mem_write` equals `cmd_write` for every command kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 single, 1 multi-register, 2 coprocessor |
| cmd_write | input | 1 | 1 store/write, 0 load/read |
| cmd_size | input | 2 | Requested size for single transfers |
| cmd_count | input | CW | Word count for multi-register transfers |
| cmd_addr | input | AW | Start address |
| mem_req_n | output | 1 | Memory request, active low |
| mem_seq | output | 1 | Current access is sequential |
| mem_more | output | 1 | Next cycle will be sequential |
| mem_write | output | 1 | Direction of the current beat |
| mem_size | output | 2 | Size code of the current beat |
| mem_addr | output | AW | Address of the current beat |
| pipe_stall | output | 1 | Holds the instruction pipeline |

## Verification
Multi-register transfers are swept over every count from 0 to the largest count a small configuration allows, in both directions. This separates the degenerate counts 0 and 1 from real bursts and pins the look-ahead flag to exactly N−1 beats. Single transfers are run with all four size codes in both directions, which shows that sizes pass through and that the reserved code is replaced. Coprocessor transfers with mismatched size requests confirm that the size is forced to word and that no memory request is made. A burst followed at once by another command checks that the sequential flag resets at the boundary and that no gap cycle appears.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_MULTI  = 2'd1,
    OP_COPRO  = 2'd2,
    OP_SPARE  = 2'd3
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode
  import dbc_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [1:0]    op,
  input  logic [1:0]    size_in,
  input  logic [CW-1:0] count,
  output logic [1:0]    eff_size,
  output logic [CW-1:0] beats,
  output logic          is_mem,
  output logic          is_burst
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    eff_size = SZ_WORD;
    beats    = ONE;
    is_mem   = 1'b1;
    is_burst = 1'b0;
    unique case (op_e'(op))
      OP_SINGLE: eff_size = (size_in == SZ_RSVD) ? SZ_WORD : size_in;
      OP_MULTI: begin
        beats    = (count > ONE) ? count : ONE;
        is_burst = (count > ONE);
      end
      OP_COPRO: is_mem = 1'b0;
      default:  eff_size = SZ_WORD;
    endcase
  end

  always_comb begin
    AST_DEC_NO_RSVD: assert (eff_size != SZ_RSVD); // R3
  end
endmodule

// File: rtl/dbc_beat_ctr.sv
module dbc_beat_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] beats,
  output logic          active,
  output logic          first,
  output logic          last,
  output logic [CW-1:0] left
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      left   <= '0;
    end else if (load) begin
      active <= 1'b1;
      first  <= 1'b1;
      left   <= beats - CW'(1);
    end else if (active) begin
      first <= 1'b0;
      if (left == '0) active <= 1'b0;
      else            left   <= left - CW'(1);
    end
  end

  assign last = active && (left == '0);

  AST_CTR_FIRST_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> active); // R5
  AST_CTR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !load) |=> (active && left == $past(left) - CW'(1))); // R4
endmodule

// File: rtl/dburst_ctrl.sv
module dburst_ctrl
  import dbc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_write,
  input  logic [1:0]    cmd_size,
  input  logic [CW-1:0] cmd_count,
  input  logic [AW-1:0] cmd_addr,
  output logic          mem_req_n,
  output logic          mem_seq,
  output logic          mem_more,
  output logic          mem_write,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic          pipe_stall
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [1:0]    dec_size;
  logic [CW-1:0] dec_beats;
  logic          dec_mem, dec_burst;
  logic          take;
  logic          b_active, b_first, b_last;
  logic [CW-1:0] b_left;
  logic          r_mem, r_burst, r_write;
  logic [1:0]    r_size;
  logic [AW-1:0] r_addr;

  dbc_decode #(.CW(CW)) u_dec (
    .op(cmd_op), .size_in(cmd_size), .count(cmd_count),
    .eff_size(dec_size), .beats(dec_beats),
    .is_mem(dec_mem), .is_burst(dec_burst)
  );

  assign cmd_ready = !b_active || b_last;
  assign take      = cmd_valid && cmd_ready;

  dbc_beat_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(take), .beats(dec_beats),
    .active(b_active), .first(b_first), .last(b_last), .left(b_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_mem   <= 1'b0;
      r_burst <= 1'b0;
      r_write <= 1'b0;
      r_size  <= SZ_WORD;
      r_addr  <= '0;
    end else if (take) begin
      r_mem   <= dec_mem;
      r_burst <= dec_burst;
      r_write <= cmd_write;
      r_size  <= dec_size;
      r_addr  <= cmd_addr;
    end else if (b_active) begin
      r_addr  <= r_addr + WORD_STEP;
    end
  end

  assign mem_req_n  = !(b_active && r_mem);
  assign mem_seq    = b_active && r_burst && !b_first;
  assign mem_more   = b_active && r_burst && (b_left != '0);
  assign pipe_stall = b_active && r_burst;
  assign mem_write  = r_write;
  assign mem_size   = r_size;
  assign mem_addr   = r_addr;

  AST_SIZE_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_size != SZ_RSVD); // R3
  AST_MORE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_more |-> (!mem_req_n && pipe_stall)); // R7
  AST_MORE_THEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_more |=> mem_seq); // R6
  AST_NOMORE_THEN_NOSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_more |=> !mem_seq); // R6
  AST_SEQ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_seq |-> (mem_addr == $past(mem_addr) + WORD_STEP)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !b_active |-> (mem_req_n && !mem_seq && !mem_more && !pipe_stall)); // R1
  AST_COPRO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_active && mem_req_n) |-> (mem_size == SZ_WORD)); // R10
endmodule

// File: tb/dburst_ctrl_bench.sv
module dburst_ctrl_bench;
  localparam int AW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic          cmd_write = 1'b0;
  logic [1:0]    cmd_size = 2'd0;
  logic [CW-1:0] cmd_count = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          mem_req_n, mem_seq, mem_more, mem_write, pipe_stall;
  logic [1:0]    mem_size;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dburst_ctrl #(.AW(AW), .CW(CW)) u_dburst_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_write(cmd_write), .cmd_size(cmd_size),
    .cmd_count(cmd_count), .cmd_addr(cmd_addr), .mem_req_n(mem_req_n),
    .mem_seq(mem_seq), .mem_more(mem_more), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .pipe_stall(pipe_stall)
  );

  // {ready, req_n, seq, more, stall, write, size, addr}
  task automatic cmp(input string tag, input logic [AW+7:0] exp);
    logic [AW+7:0] act;
    act = {cmd_ready, mem_req_n, mem_seq, mem_more, pipe_stall, mem_write,
           mem_size, mem_addr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    cmp(tag, {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, mem_write, mem_size, mem_addr});
  endtask

  // Offer a command at a negedge; the first beat appears at the next negedge.
  task automatic offer(input logic [1:0] op, input logic wr, input logic [1:0] sz,
                       input logic [CW-1:0] cnt, input logic [AW-1:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_write = wr;
    cmd_size = sz; cmd_count = cnt; cmd_addr = a;
  endtask

  task automatic run_multi(input logic wr, input int n, input logic [AW-1:0] base);
    int beats;
    bit burst;
    beats = (n > 1) ? n : 1;
    burst = (n > 1);
    offer(2'd1, wr, 2'd0, CW'(n), base);
    if (pipe_stall !== 1'b0) begin   // R8 acceptance cycle leaves a fetch slot
      fails++; $display("FAIL R8 stall in accept cycle actual=%b expected=0", pipe_stall);
    end
    checks++;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < beats; k++) begin
      // R4 R5 R6 R8 R9 R11 R12
      cmp(burst ? "R4/R5/R6/R8/R11 burst beat" : "R9 short multi beat",
          {k == beats - 1, 1'b0, burst && k > 0, burst && k < beats - 1,
           burst, wr, 2'b10, base + AW'(4 * k)});
      @(negedge clk);
    end
    idle_chk("R1 idle after multi");
  endtask

  task automatic run_single(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a);
    offer(2'd0, wr, sz, CW'(5), a);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2 R3 R12
    cmp("R2/R3/R12 single beat",
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, wr, (sz == 2'b11) ? 2'b10 : sz, a});
    @(negedge clk);
    idle_chk("R1 idle after single");
  endtask

  task automatic run_copro(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a);
    offer(2'd2, wr, sz, CW'(3), a);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R10
    cmp("R10 coprocessor beat", {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, wr, 2'b10, a});
    @(negedge clk);
    idle_chk("R1 idle after coprocessor");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 idle after reset release");

    for (int w = 0; w < 2; w++)
      for (int n = 0; n < (1 << CW); n++)
        run_multi(w[0], n, AW'(16'h1000 + 64 * n + 2 * w));

    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        run_single(w[0], s[1:0], AW'(16'h2001 + 16 * s + w));

    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        run_copro(w[0], s[1:0], AW'(16'h3000 + 4 * s + w));

    // R11 back-to-back: 3-word store, then a single halfword load offered on its last beat
    offer(2'd1, 1'b1, 2'd0, CW'(3), AW'(16'h4000));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmp("R11 b2b beat0", {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, AW'(16'h4000)});
    @(negedge clk);
    cmp("R11 b2b beat1", {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, AW'(16'h4004)});
    @(negedge clk);
    cmp("R11 b2b last beat ready", {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, AW'(16'h4008)});
    offer(2'd0, 1'b0, 2'b01, CW'(0), AW'(16'h5002));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmp("R11/R6 b2b follow-on single",
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, AW'(16'h5002)});
    @(negedge clk);
    idle_chk("R1 idle after b2b");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule